// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Matched Read and Write Latency

This block is a synthesizable model of a 32-bit-wide synchronous static RAM. A host can switch its bus between reads and writes on consecutive cycles without inserting idle cycles. The address, the command and the byte write enables are captured at a rising clock edge. Two accepted edges later the data moves: a read drives its word from that edge onward, and a write takes its word from `data_in` at that edge. Because both directions have the same delay, a write placed between two reads never collides with a read word on the bus.

A command either loads a new address, starting a single access or a four-beat burst, or advances the burst that is already open. The burst visits its four words in one of two orders. In the interleaved order the low address bits are XOR-ed with the beat count. In the linear order the beat count is added to the low address bits, wrapping within the group of four. A clock-enable input, when high, makes the block skip an edge entirely. The bidirectional bus is split into separate `data_in`, `data_out` and `data_oe` signals, and the three-state buffer is built outside the block. An active-low output enable gates `data_oe` without passing through a register.

The array depth is set by the address width parameter. The array read is registered, one edge before the data phase. A write that is still finishing when a later read samples the array is forwarded into that read's result.

Top module: `nbt_sram`

## Requirements
- R1: While reset is asserted and after it is released, with no command accepted yet, `data_oe` is 0 and `data_out` is 0.
- R2: An accepted edge with the device selected, `adv_ld`=0 and `rw_sel`=1 starts a read. The word at `addr` appears on `data_out`, with `read phase` set, from the second accepted edge after it.
- R3: An accepted edge with the device selected, `adv_ld`=0 and `rw_sel`=0 starts a write. At the second accepted edge after it, each lane i with `byte_we_n[i]`=0 takes `data_in[8i+7:8i]`, and lanes with the bit at 1 keep their old value.
- R4: Reads and writes may alternate on every accepted edge with no idle edge between them. A read that immediately follows a write to the same address returns the newly written bytes merged with the unwritten ones.
- R5: An edge with `clk_en_n`=1 is ignored. Commands are not taken, no write happens, and `data_out`/`data_oe` keep their values, except for the effect of `out_en_n`.
- R6: `adv_ld`=1 on an accepted edge issues the next beat of the open burst, in the direction set when the burst was loaded. During such an edge `rw_sel`, `addr` and the selects are ignored. With `burst_linear`=0 the low two address bits of beat k (k=0..3, wrapping) are start XOR k.
- R7: With `burst_linear`=1 the low two address bits of beat k are (start + k) mod 4, and the upper address bits stay fixed.
- R8: An accepted edge with `adv_ld`=0 and the device not selected is a deselect. `data_oe` is 0 from the second accepted edge after it. An advance issued after a deselect, before a new load, performs no access.
- R9: The device counts as selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is treated as not selected.
- R10: `data_oe` equals (read phase active) AND NOT `out_en_n`, and follows `out_en_n` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high ignores the edge |
| addr | input | ADDR_W | Word address, used when a burst is loaded |
| rw_sel | input | 1 | 1 read, 0 write, sampled when a burst is loaded |
| adv_ld | input | 1 | 1 advances the open burst, 0 loads a new command |
| sel_a_n | input | 1 | Active-low select |
| sel_b | input | 1 | Active-high select |
| sel_c_n | input | 1 | Active-low select |
| byte_we_n | input | 4 | Active-low byte lane write enables, bit i for bits 8i+7:8i |
| burst_linear | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| data_in | input | 32 | Write data, sampled in the write data phase |
| data_out | output | 32 | Read data |
| data_oe | output | 1 | Drive enable for the external three-state buffer |

## Verification
The hardest situation to reach from the ports is a read that samples the array on the same edge at which an earlier write to that address commits. In that case the correct word exists only in the forwarding path. The stimulus produces it with write-then-read pairs to one address on back-to-back edges, using partial byte masks so that merged and unmerged lanes can be told apart. Clock-enable stalls are inserted between the two commands and between the command and its data phase, so the pipeline slots hold still across the stall. A long random phase then mixes loads, advances in both burst orders, deselects, partial selects, stalls and output-enable changes.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

    localparam int NBT_DATA_W  = 32;
    localparam int NBT_LANES   = 4;
    localparam int NBT_LANE_W  = NBT_DATA_W / NBT_LANES;
    localparam int NBT_BURST_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_kind_e;

    // Low address bits of a burst beat for either ordering.
    function automatic logic [NBT_BURST_W-1:0] burst_step(
        input logic [NBT_BURST_W-1:0] start,
        input logic [NBT_BURST_W-1:0] beat,
        input logic                   linear
    );
        return linear ? (start + beat) : (start ^ beat);
    endfunction

endpackage

// File: rtl/nbt_cmd_seq.sv
// Command decode and burst address sequencing.
module nbt_cmd_seq
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc,
    input  logic                 sel_ok,
    input  logic                 adv_ld,
    input  logic                 rw_sel,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NBT_LANES-1:0] byte_we_n,
    input  logic                 burst_linear,
    output op_kind_e             op_kind,
    output logic [ADDR_W-1:0]    op_addr,
    output logic [NBT_LANES-1:0] op_bwe_n
);

    localparam int HI_W = ADDR_W - NBT_BURST_W;

    typedef struct packed {
        logic [ADDR_W-1:0]      base;
        logic [NBT_BURST_W-1:0] beat;
        logic                   is_read;
        logic                   open;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [NBT_BURST_W-1:0] beat_nx;

    always_comb begin
        seq_d    = seq_q;
        op_kind  = OP_IDLE;
        op_addr  = seq_q.base;
        op_bwe_n = byte_we_n;
        beat_nx  = seq_q.beat + 1'b1;
        if (!adv_ld) begin
            if (sel_ok) begin
                seq_d.base    = addr;
                seq_d.beat    = '0;
                seq_d.is_read = rw_sel;
                seq_d.open    = 1'b1;
                op_kind       = rw_sel ? OP_RD : OP_WR;
                op_addr       = addr;
            end else begin
                seq_d.open = 1'b0;
            end
        end else if (seq_q.open) begin
            seq_d.beat = beat_nx;
            op_kind    = seq_q.is_read ? OP_RD : OP_WR;
            op_addr    = {seq_q.base[ADDR_W-1 -: HI_W],
                          burst_step(seq_q.base[NBT_BURST_W-1:0], beat_nx, burst_linear)};
        end
        if (!acc) begin
            seq_d = seq_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/nbt_pipe.sv
// Two command slots between the address edge and the data edge.
module nbt_pipe
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc,
    input  op_kind_e             in_kind,
    input  logic [ADDR_W-1:0]    in_addr,
    input  logic [NBT_LANES-1:0] in_bwe_n,
    output op_kind_e             s1_kind,
    output logic [ADDR_W-1:0]    s1_addr,
    output op_kind_e             s2_kind,
    output logic [ADDR_W-1:0]    s2_addr,
    output logic [NBT_LANES-1:0] s2_bwe_n
);

    typedef struct packed {
        op_kind_e               kind;
        logic [ADDR_W-1:0]      addr;
        logic [NBT_LANES-1:0]   bwe_n;
    } slot_t;

    typedef struct packed {
        slot_t first;
        slot_t second;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        if (acc) begin
            pipe_d.second      = pipe_q.first;
            pipe_d.first.kind  = in_kind;
            pipe_d.first.addr  = in_addr;
            pipe_d.first.bwe_n = in_bwe_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '{first: '{kind: OP_IDLE, addr: '0, bwe_n: '1},
                        second: '{kind: OP_IDLE, addr: '0, bwe_n: '1}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign s1_kind  = pipe_q.first.kind;
    assign s1_addr  = pipe_q.first.addr;
    assign s2_kind  = pipe_q.second.kind;
    assign s2_addr  = pipe_q.second.addr;
    assign s2_bwe_n = pipe_q.second.bwe_n;

endmodule

// File: rtl/nbt_store.sv
// Byte-lane storage array with registered read.
module nbt_store
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [NBT_DATA_W-1:0] wr_data,
    input  logic [NBT_LANES-1:0]  wr_bwe_n,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [NBT_DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NBT_LANES; g++) begin : g_lane
        logic [NBT_LANE_W-1:0] lane_mem [DEPTH];
        logic [NBT_LANE_W-1:0] lane_rd_q;

        always_ff @(posedge clk) begin
            if (wr_en && !wr_bwe_n[g]) begin
                lane_mem[wr_addr] <= wr_data[g*NBT_LANE_W +: NBT_LANE_W];
            end
        end

        always_ff @(posedge clk) begin
            if (rd_en) begin
                lane_rd_q <= lane_mem[rd_addr];
            end
        end

        assign rd_data[g*NBT_LANE_W +: NBT_LANE_W] = lane_rd_q;
    end

endmodule

// File: rtl/nbt_sram.sv
// Top: decode, pipeline, array, and read output stage with write forwarding.
module nbt_sram
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clk_en_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  rw_sel,
    input  logic                  adv_ld,
    input  logic                  sel_a_n,
    input  logic                  sel_b,
    input  logic                  sel_c_n,
    input  logic [NBT_LANES-1:0]  byte_we_n,
    input  logic                  burst_linear,
    input  logic                  out_en_n,
    input  logic [NBT_DATA_W-1:0] data_in,
    output logic [NBT_DATA_W-1:0] data_out,
    output logic                  data_oe
);

    typedef struct packed {
        logic                  rd_phase;
        logic [NBT_DATA_W-1:0] dout;
        logic                  wl_valid;
        logic [ADDR_W-1:0]     wl_addr;
        logic [NBT_DATA_W-1:0] wl_data;
        logic [NBT_LANES-1:0]  wl_bwe_n;
    } out_t;

    logic                  acc;
    logic                  sel_ok;
    op_kind_e              op_kind;
    logic [ADDR_W-1:0]     op_addr;
    logic [NBT_LANES-1:0]  op_bwe_n;
    op_kind_e              s1_kind;
    logic [ADDR_W-1:0]     s1_addr;
    op_kind_e              s2_kind;
    logic [ADDR_W-1:0]     s2_addr;
    logic [NBT_LANES-1:0]  s2_bwe_n;
    logic [NBT_DATA_W-1:0] rd_word;
    logic [NBT_DATA_W-1:0] merged;
    out_t                  out_d, out_q;

    assign acc    = !clk_en_n;
    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    nbt_cmd_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc          (acc),
        .sel_ok       (sel_ok),
        .adv_ld       (adv_ld),
        .rw_sel       (rw_sel),
        .addr         (addr),
        .byte_we_n    (byte_we_n),
        .burst_linear (burst_linear),
        .op_kind      (op_kind),
        .op_addr      (op_addr),
        .op_bwe_n     (op_bwe_n)
    );

    nbt_pipe #(.ADDR_W(ADDR_W)) pipe_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .in_kind  (op_kind),
        .in_addr  (op_addr),
        .in_bwe_n (op_bwe_n),
        .s1_kind  (s1_kind),
        .s1_addr  (s1_addr),
        .s2_kind  (s2_kind),
        .s2_addr  (s2_addr),
        .s2_bwe_n (s2_bwe_n)
    );

    nbt_store #(.ADDR_W(ADDR_W)) store_i (
        .clk      (clk),
        .wr_en    (acc && (s2_kind == OP_WR)),
        .wr_addr  (s2_addr),
        .wr_data  (data_in),
        .wr_bwe_n (s2_bwe_n),
        .rd_en    (acc && (s1_kind == OP_RD)),
        .rd_addr  (s1_addr),
        .rd_data  (rd_word)
    );

    always_comb begin
        out_d  = out_q;
        merged = rd_word;
        for (int g = 0; g < NBT_LANES; g++) begin
            if (out_q.wl_valid && (out_q.wl_addr == s2_addr) && !out_q.wl_bwe_n[g]) begin
                merged[g*NBT_LANE_W +: NBT_LANE_W] = out_q.wl_data[g*NBT_LANE_W +: NBT_LANE_W];
            end
        end
        if (acc) begin
            out_d.wl_valid = (s2_kind == OP_WR);
            out_d.wl_addr  = s2_addr;
            out_d.wl_data  = data_in;
            out_d.wl_bwe_n = s2_bwe_n;
            out_d.rd_phase = (s2_kind == OP_RD);
            if (s2_kind == OP_RD) begin
                out_d.dout = merged;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign data_out = out_q.dout;
    assign data_oe  = out_q.rd_phase && !out_en_n;

endmodule

// File: rtl/nbt_sram_chk.sv
// Port-level properties, bound into the top module.
module nbt_sram_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clk_en_n,
    input logic        adv_ld,
    input logic        rw_sel,
    input logic        sel_a_n,
    input logic        sel_b,
    input logic        sel_c_n,
    input logic        out_en_n,
    input logic [31:0] data_out,
    input logic        data_oe
);

    logic sel_full;
    logic desel_now;
    logic rd_now;
    logic ds1_q, ds2_q, ds3_q;
    logic rd1_q, rd2_q, rd3_q;

    assign sel_full  = !sel_a_n && sel_b && !sel_c_n;
    assign desel_now = !adv_ld && !sel_full;
    assign rd_now    = !adv_ld && sel_full && rw_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {ds1_q, ds2_q, ds3_q} <= '0;
            {rd1_q, rd2_q, rd3_q} <= '0;
        end else if (!clk_en_n) begin
            ds1_q <= desel_now;
            ds2_q <= ds1_q;
            ds3_q <= ds2_q;
            rd1_q <= rd_now;
            rd2_q <= rd1_q;
            rd3_q <= rd2_q;
        end
    end

    AST_OE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !out_en_n); // R10

    AST_STALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(data_out)); // R5

    AST_DESELECT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        ds3_q |-> !data_oe); // R8

    AST_READ_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd3_q && !out_en_n) |-> data_oe); // R2

endmodule

bind nbt_sram nbt_sram_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .adv_ld   (adv_ld),
    .rw_sel   (rw_sel),
    .sel_a_n  (sel_a_n),
    .sel_b    (sel_b),
    .sel_c_n  (sel_c_n),
    .out_en_n (out_en_n),
    .data_out (data_out),
    .data_oe  (data_oe)
);

// File: tb/nbt_sram_tb_top.sv
module nbt_sram_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int AW = 6;
    localparam int NWORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          rw_sel = 1'b1;
    logic          adv_ld = 1'b0;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b1;
    logic          sel_c_n = 1'b0;
    logic [3:0]    byte_we_n = 4'hF;
    logic          burst_linear = 1'b0;
    logic          out_en_n = 1'b0;
    logic [31:0]   data_in = '0;
    logic [31:0]   data_out;
    logic          data_oe;

    always #2.5 clk = ~clk;

    nbt_sram #(.ADDR_W(AW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_en_n     (clk_en_n),
        .addr         (addr),
        .rw_sel       (rw_sel),
        .adv_ld       (adv_ld),
        .sel_a_n      (sel_a_n),
        .sel_b        (sel_b),
        .sel_c_n      (sel_c_n),
        .byte_we_n    (byte_we_n),
        .burst_linear (burst_linear),
        .out_en_n     (out_en_n),
        .data_in      (data_in),
        .data_out     (data_out),
        .data_oe      (data_oe)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: memory, open-burst state, queue of issued accesses.
    typedef struct packed {
        logic [1:0]    kind;   // 0 none, 1 read, 2 write
        logic [AW-1:0] a;
        logic [3:0]    bw;
    } mop_t;

    mop_t          pend[$];
    logic [31:0]   mmem [NWORDS];
    bit            m_rd = 1'b0;
    logic [31:0]   m_dout = '0;
    logic [AW-1:0] m_base = '0;
    int            m_beat = 0;
    bit            m_dir = 1'b0;
    bit            m_open = 1'b0;

    always @(posedge clk) begin
        mop_t op;
        mop_t x;
        logic [1:0] lo;
        if (!rst_n) begin
            pend.delete();
            m_rd = 1'b0;
            m_dout = '0;
            m_open = 1'b0;
        end else if (!clk_en_n) begin
            op = '0;
            op.bw = byte_we_n;
            if (!adv_ld) begin
                if (!sel_a_n && sel_b && !sel_c_n) begin
                    m_base = addr;
                    m_beat = 0;
                    m_dir = rw_sel;
                    m_open = 1'b1;
                    op.kind = rw_sel ? 2'd1 : 2'd2;
                    op.a = addr;
                end else begin
                    m_open = 1'b0;
                end
            end else if (m_open) begin
                m_beat = (m_beat + 1) % 4;
                if (burst_linear) lo = m_base[1:0] + 2'(m_beat);
                else              lo = m_base[1:0] ^ 2'(m_beat);
                op.kind = m_dir ? 2'd1 : 2'd2;
                op.a = {m_base[AW-1:2], lo};
            end
            pend.push_back(op);
            if (pend.size() > 2) begin
                x = pend.pop_front();
                m_rd = (x.kind == 2'd1);
                if (x.kind == 2'd1) m_dout = mmem[x.a];
                if (x.kind == 2'd2) begin
                    for (int l = 0; l < 4; l++)
                        if (!x.bw[l]) mmem[x.a][l*8 +: 8] = data_in[l*8 +: 8];
                end
            end
        end
    end

    // Cycle comparison, away from the active edge.
    always begin
        @(negedge clk);
        #1;
        if (rst_n && cmp_on) begin
            check(cur_req, {31'd0, data_oe}, {31'd0, (m_rd && !out_en_n)}, "data_oe");
            if (m_rd) check(cur_req, data_out, m_dout, "data_out");
        end
    end

    task automatic put(input bit sa_n, input bit sb, input bit sc_n, input bit adv,
                       input bit rw, input logic [AW-1:0] a, input logic [3:0] bw,
                       input bit cen);
        @(negedge clk);
        sel_a_n = sa_n; sel_b = sb; sel_c_n = sc_n;
        adv_ld = adv; rw_sel = rw; addr = a; byte_we_n = bw;
        clk_en_n = cen; data_in = $urandom;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        put(0, 1, 0, 0, 1, a, 4'hF, 0);
    endtask
    task automatic wr(input logic [AW-1:0] a, input logic [3:0] bw);
        put(0, 1, 0, 0, 0, a, bw, 0);
    endtask
    task automatic adv(input logic [3:0] bw);
        put($urandom_range(1, 0) != 0, $urandom_range(1, 0) != 0, $urandom_range(1, 0) != 0,
            1, $urandom_range(1, 0) != 0, AW'($urandom), bw, 0);
    endtask
    task automatic idle();
        put(1, 1, 0, 0, 1, '0, 4'hF, 0);
    endtask
    task automatic stall();
        put($urandom_range(1, 0) != 0, 1, 0, $urandom_range(1, 0) != 0, 0, AW'($urandom), 4'h0, 1);
    endtask
    task automatic flush();
        idle(); idle(); idle();
    endtask

    initial begin
        logic [31:0] held;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R1", {31'd0, data_oe}, 32'd0, "data_oe in reset");
        check("R1", data_out, 32'd0, "data_out in reset");
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1", {31'd0, data_oe}, 32'd0, "data_oe after reset");
        check("R1", data_out, 32'd0, "data_out after reset");
        cmp_on = 1'b1;

        // R3: fill every word, then partial-lane writes and read-back
        cur_req = "R3";
        for (int i = 0; i < NWORDS; i++) wr(AW'(i), 4'h0);
        flush();
        wr(6'd3, 4'b1110); wr(6'd4, 4'b0101); wr(6'd5, 4'b1111); wr(6'd6, 4'b0111);
        flush();
        rd(6'd3); rd(6'd4); rd(6'd5); rd(6'd6);
        flush();

        // R2: single reads of several words
        cur_req = "R2";
        for (int i = 0; i < 12; i++) rd(AW'(i * 5));
        flush();

        // R4: alternating write/read, same-address pairs with partial masks
        cur_req = "R4";
        for (int i = 0; i < 10; i++) begin
            wr(AW'(i + 20), 4'($urandom));
            rd(AW'(i + 20));
        end
        wr(6'd7, 4'b1001); rd(6'd7); wr(6'd7, 4'b0110); rd(6'd7); rd(6'd7);
        flush();

        // R5: stalls between command and data phase, and between dependent accesses
        cur_req = "R5";
        wr(6'd9, 4'b0011); stall(); stall(); rd(6'd9); stall(); idle(); stall(); idle();
        rd(6'd10); idle(); idle();
        @(negedge clk); #1; held = data_out;
        stall(); stall(); stall();
        @(negedge clk); #1;
        check("R5", data_out, held, "data_out across stalled edges");
        flush();

        // R6: interleaved bursts, direction held during advances
        cur_req = "R6";
        burst_linear = 1'b0;
        rd(6'd14); adv(4'h0); adv(4'h0); adv(4'h0); adv(4'h0);
        wr(6'd17, 4'b0000); adv(4'b1010); adv(4'b0000); adv(4'b0101);
        rd(6'd16); adv(4'hF); adv(4'hF); adv(4'hF);
        flush();

        // R7: linear bursts
        cur_req = "R7";
        burst_linear = 1'b1;
        rd(6'd30); adv(4'h0); adv(4'h0); adv(4'h0); adv(4'h0);
        wr(6'd41, 4'b0000); adv(4'b0000); adv(4'b1100); adv(4'b0000);
        rd(6'd40); adv(4'hF); adv(4'hF); adv(4'hF);
        flush();
        burst_linear = 1'b0;

        // R8: deselect mid-stream, then advances with no open burst
        cur_req = "R8";
        rd(6'd1); rd(6'd2); idle(); adv(4'h0); adv(4'h0); rd(6'd3); idle(); idle();
        wr(6'd50, 4'h0); idle(); adv(4'h0); adv(4'h0); rd(6'd50);
        flush();

        // R9: each partial select behaves as not selected
        cur_req = "R9";
        put(1, 1, 0, 0, 1, 6'd2, 4'hF, 0); idle(); idle();
        put(0, 0, 0, 0, 1, 6'd2, 4'hF, 0); idle(); idle();
        put(0, 1, 1, 0, 1, 6'd2, 4'hF, 0); idle(); idle();
        put(0, 0, 1, 0, 0, 6'd2, 4'h0, 0); idle(); idle(); rd(6'd2);
        flush();

        // R10: output enable toggled between edges
        cur_req = "R10";
        for (int i = 0; i < 8; i++) begin
            out_en_n = $urandom_range(1, 0) != 0;
            rd(AW'(i));
        end
        out_en_n = 1'b0;
        rd(6'd11); rd(6'd12); rd(6'd13);
        @(negedge clk); #2;
        out_en_n = 1'b1; #0.5;
        check("R10", {31'd0, data_oe}, 32'd0, "data_oe with enable released");
        out_en_n = 1'b0; #0.5;
        check("R10", {31'd0, data_oe}, {31'd0, m_rd}, "data_oe with enable restored");
        flush();

        // Mixed traffic
        cur_req = "R4";
        for (int i = 0; i < 600; i++) begin
            int k;
            k = $urandom_range(9, 0);
            if (i % 150 == 0) begin
                flush();
                burst_linear = ~burst_linear;
            end
            out_en_n = ($urandom_range(5, 0) == 0);
            case (k)
                0, 1, 2: rd(AW'($urandom));
                3, 4:    wr(AW'($urandom), 4'($urandom));
                5, 6:    adv(4'($urandom));
                7:       stall();
                8:       idle();
                default: put($urandom_range(1, 0) != 0, $urandom_range(1, 0) != 0,
                             $urandom_range(1, 0) != 0, 0, $urandom_range(1, 0) != 0,
                             AW'($urandom), 4'($urandom), 0);
            endcase
        end
        out_en_n = 1'b0;
        flush();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule